// File: doc/BRIEF.md
# Two-way interrupting mailbox with lock bank

This APB slave carries short messages between two processors, called side A and side B. Each direction has its own bank of four elements. An element is a command word, a data word and a pending flag. A sender writes the command word first and then the data word. The data write raises the flag. When the flag's enable bit is also set, the flag holds one interrupt line to the receiver high. There is one line per element: `irq_to_b` for the A-to-B bank and `irq_to_a` for the B-to-A bank. The receiver reads the words and then clears the flag by writing a 1 to its status bit.

A separate bank of 32 lock cells gives software a cheap claim-and-release primitive. A read of a lock returns its old state and claims it in the same access, so the read acts as a test-and-set. Writing zero to the lock gives it back.

The slave answers every transfer with zero wait states. Offsets that are not mapped report an error.

Top module: `ipc_mailbox`

## Requirements
- R1: The A-to-B bank is at these offsets: enable at 0x00, status at 0x04, command of element x at 0x08+8x, data of element x at 0x0C+8x. Command and data read back all 32 bits as written. Enable and status read back in bits [3:0], and their upper bits read as zero.
- R2: The B-to-A bank has the same layout at enable 0x28, status 0x2C, command 0x30+8x and data 0x34+8x. It is fully independent of the A-to-B bank.
- R3: A write to the data word of element x sets status bit x of that bank. A write to a command word leaves the status unchanged.
- R4: A status write clears every flag whose bit in the written value is 1. Flags written as 0 are kept.
- R5: `irq_to_b[x]` is a level equal to A-to-B status bit x AND enable bit x, and `irq_to_a[x]` follows the same rule for the B-to-A bank. Clearing an enable bit drops the line but keeps the flag.
- R6: A read of lock x at 0x100+8x returns 0 in bit 0 when the lock is free and claims it. A read of a claimed lock returns 1.
- R7: A lock write whose bit 0 is 0 releases the lock. A write with bit 0 equal to 1 has no effect. Locks are independent of one another.
- R8: `pready` is always 1. An access phase to any other offset, including a misaligned one, raises `pslverr`, reads 0 and changes no state.
- R9: Reset clears all command, data, status, enable and lock state, and all interrupt lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Unmapped offset in the access phase |
| irq_to_b | output | 4 | Level interrupts from the A-to-B bank |
| irq_to_a | output | 4 | Level interrupts from the B-to-A bank |

## Verification
The bench targets the following corner cases:
- **Command write must not raise a flag.** A design that raised flags on command writes would interrupt before the data word lands.
- **Partial status clear.** A design that cleared on writes of 0, or that overwrote the whole status, would lose other pending flags.
- **Enable turned off while a flag is pending.** A design that latched the interrupt would keep the line up.
- **Two reads of the same lock.** A lock that was not claimed on read would return 0 twice and let two owners in.
- **Lock write with bit 0 set.** A design that released on any write would release here.
- **Misaligned offsets and gap offsets.** Gap offsets include the odd slots between locks. A design that decoded only the upper address bits would accept these accesses and corrupt a neighbouring register.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int ELEMS = 4,
  parameter int LOCKS = 32,
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int LBASE = 'h100
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  output logic             pready,
  output logic             pslverr,
  output logic [ELEMS-1:0] irq_to_b,
  output logic [ELEMS-1:0] irq_to_a
);
  localparam int BANK = 8 + 8 * ELEMS;
  localparam int LW   = $clog2(LOCKS);

  logic [1:0][ELEMS-1:0] en, sta, irq;
  logic [DW-1:0] cmd [2][ELEMS];
  logic [DW-1:0] dat [2][ELEMS];
  logic [LOCKS-1:0] lock;

  logic [31:0] off;
  logic acc, wr, rd, hit, lk_hit;
  logic [1:0] we_en, we_sta;
  logic [1:0][ELEMS-1:0] we_cmd, we_dat;
  logic [LW-1:0] lk_idx;
  logic [DW-1:0] rdata;

  assign off    = 32'(paddr);
  assign acc    = psel & penable;
  assign wr     = acc & pwrite;
  assign rd     = acc & ~pwrite;
  assign pready = 1'b1;

  always_comb begin
    hit = 1'b0; lk_hit = 1'b0; lk_idx = '0; rdata = '0;
    we_en = '0; we_sta = '0; we_cmd = '0; we_dat = '0;
    for (int d = 0; d < 2; d++) begin
      if (off == 32'(d * BANK)) begin
        hit = 1'b1; we_en[d] = 1'b1; rdata = DW'(en[d]);
      end
      if (off == 32'(d * BANK + 4)) begin
        hit = 1'b1; we_sta[d] = 1'b1; rdata = DW'(sta[d]);
      end
      for (int e = 0; e < ELEMS; e++) begin
        if (off == 32'(d * BANK + 8 + 8 * e)) begin
          hit = 1'b1; we_cmd[d][e] = 1'b1; rdata = cmd[d][e];
        end
        if (off == 32'(d * BANK + 12 + 8 * e)) begin
          hit = 1'b1; we_dat[d][e] = 1'b1; rdata = dat[d][e];
        end
      end
    end
    for (int l = 0; l < LOCKS; l++) begin
      if (off == 32'(LBASE + 8 * l)) begin
        hit = 1'b1; lk_hit = 1'b1; lk_idx = LW'(l); rdata = DW'(lock[l]);
      end
    end
  end

  assign prdata  = (rd && hit) ? rdata : '0;
  assign pslverr = acc & ~hit;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      en   <= '0;
      sta  <= '0;
      lock <= '0;
      for (int d = 0; d < 2; d++)
        for (int e = 0; e < ELEMS; e++) begin
          cmd[d][e] <= '0;
          dat[d][e] <= '0;
        end
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (wr && we_en[d]) en[d] <= pwdata[ELEMS-1:0];
        for (int e = 0; e < ELEMS; e++) begin
          if (wr && we_cmd[d][e]) cmd[d][e] <= pwdata;
          if (wr && we_dat[d][e]) begin
            dat[d][e] <= pwdata;
            sta[d][e] <= 1'b1;
          end else if (wr && we_sta[d] && pwdata[e]) begin
            sta[d][e] <= 1'b0;
          end
        end
      end
      if (acc && lk_hit) begin
        if (!pwrite) lock[lk_idx] <= 1'b1;
        else if (!pwdata[0]) lock[lk_idx] <= 1'b0;
      end
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar e = 0; e < ELEMS; e++) begin : g_el
      assign irq[d][e] = sta[d][e] & en[d][e];

      a_r3_data_sets_flag: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr == AW'(d * BANK + 12 + 8 * e)) |=> sta[d][e]);

      a_r4_w1c_clears: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr == AW'(d * BANK + 4) && pwdata[e]) |=> !sta[d][e]);

      a_r5_irq_follows: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr == AW'(d * BANK + 12 + 8 * e) && en[d][e]) |=> irq[d][e]);
    end
  end

  assign irq_to_b = irq[0];
  assign irq_to_a = irq[1];

  a_r6_lock_claimed: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && lk_hit) |=> lock[$past(lk_idx)]);

  a_r7_lock_released: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && lk_hit && !pwdata[0]) |=> !lock[$past(lk_idx)]);

  a_r8_err_in_access: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> (psel && penable && prdata == '0));

  a_r8_ready: assert property (@(posedge pclk) disable iff (!presetn) pready);
endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  typedef struct {
    logic [31:0] data;
    logic        err;
    logic        is_rd;
    string       tag;
  } exp_t;

  logic pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr;
  logic [3:0] irq_to_b, irq_to_a;
  int total = 0, bad = 0;
  exp_t q[$];

  ipc_mailbox uut (.pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq_to_b(irq_to_b), .irq_to_a(irq_to_a));

  always #10 pclk = ~pclk;

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge pclk) begin
    if (psel && penable) begin
      exp_t it;
      if (q.size() == 0) begin
        check(32'd1, 32'd0, "scoreboard underflow");
      end else begin
        it = q.pop_front();
        check(32'(pslverr), 32'(it.err), {it.tag, " pslverr"});
        check(32'(pready), 32'd1, "R8 pready");
        if (it.is_rd) check(prdata, it.data, it.tag);
      end
    end
  end

  task automatic acc(logic w, logic [11:0] a, logic [31:0] d, logic [31:0] ex, logic er, string tag);
    exp_t it;
    it.data = ex; it.err = er; it.is_rd = !w; it.tag = tag;
    q.push_back(it);
    @(posedge pclk); #1 psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
    @(posedge pclk); #1 penable = 1;
    @(posedge pclk); #1 psel = 0; penable = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    acc(1'b1, a, d, '0, 1'b0, tag);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] ex, string tag);
    acc(1'b0, a, '0, ex, 1'b0, tag);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge pclk);
    #1 presetn = 1;
    check(32'(irq_to_b), 0, "R9 irq_to_b reset");
    check(32'(irq_to_a), 0, "R9 irq_to_a reset");
    rd(12'h000, 0, "R9 enable reset");
    rd(12'h004, 0, "R9 status reset");
    rd(12'h01C, 0, "R9 data reset");
    rd(12'h02C, 0, "R9 b2a status reset");

    // R1 layout and readback
    wr(12'h018, 32'hCAFE0002, "R1");
    rd(12'h018, 32'hCAFE0002, "R1 cmd readback");
    wr(12'h000, 32'hFFFFFFFF, "R1");
    rd(12'h000, 32'h0000000F, "R1 enable width");
    // R3 command write does not set flag
    rd(12'h004, 0, "R3 cmd no flag");
    check(32'(irq_to_b), 0, "R3 no irq after cmd");
    wr(12'h01C, 32'h12345678, "R3");
    rd(12'h004, 32'h4, "R3 data sets flag");
    rd(12'h01C, 32'h12345678, "R1 data readback");
    check(32'(irq_to_b), 32'h4, "R5 irq_to_b on");
    check(32'(irq_to_a), 0, "R2 other bank quiet");

    // R2 B-to-A bank
    wr(12'h030, 32'hA5A5A5A5, "R2");
    wr(12'h03C, 32'h00000077, "R2");
    rd(12'h030, 32'hA5A5A5A5, "R2 cmd readback");
    rd(12'h02C, 32'h2, "R2 status");
    check(32'(irq_to_a), 0, "R5 disabled line low");
    wr(12'h028, 32'h2, "R2");
    check(32'(irq_to_a), 32'h2, "R5 irq_to_a on");
    rd(12'h008, 0, "R2 banks independent");

    // R4 write-one-to-clear
    wr(12'h00C, 32'h1, "R4");
    wr(12'h024, 32'h3, "R4");
    rd(12'h004, 32'hD, "R4 three flags");
    wr(12'h004, 32'h4, "R4");
    rd(12'h004, 32'h9, "R4 partial clear");
    check(32'(irq_to_b), 32'h9, "R5 level holds");
    wr(12'h004, 32'h0, "R4");
    rd(12'h004, 32'h9, "R4 zero write keeps");

    // R5 enable gating
    wr(12'h000, 32'h0, "R5");
    check(32'(irq_to_b), 0, "R5 enable off drops line");
    rd(12'h004, 32'h9, "R5 flag kept");
    wr(12'h000, 32'h8, "R5");
    check(32'(irq_to_b), 32'h8, "R5 partial enable");

    // R6/R7 locks
    rd(12'h128, 0, "R6 free lock reads 0");
    rd(12'h128, 1, "R6 held lock reads 1");
    rd(12'h130, 0, "R7 neighbour independent");
    wr(12'h128, 32'h1, "R7");
    rd(12'h128, 1, "R7 write bit0=1 no effect");
    wr(12'h128, 32'h0, "R7");
    rd(12'h128, 0, "R7 released");
    rd(12'h1F8, 0, "R6 last lock");

    // R8 unmapped
    acc(1'b0, 12'h104, 0, 0, 1'b1, "R8 gap read");
    acc(1'b1, 12'h0FC, 32'hFFFFFFFF, 0, 1'b1, "R8 unmapped write");
    acc(1'b0, 12'h050, 0, 0, 1'b1, "R8 past b2a bank");
    acc(1'b0, 12'h009, 0, 0, 1'b1, "R8 misaligned read");
    acc(1'b1, 12'h00E, 32'hDEADBEEF, 0, 1'b1, "R8 misaligned write");
    rd(12'h00C, 32'h1, "R8 no side effect");
    acc(1'b1, 12'h12C, 32'h0, 0, 1'b1, "R8 odd lock slot");
    rd(12'h130, 1, "R8 lock kept");

    // R9 reset mid-run
    @(posedge pclk); #1 presetn = 0;
    @(posedge pclk); #1 presetn = 1;
    check(32'(irq_to_b), 0, "R9 irq cleared");
    rd(12'h004, 0, "R9 status cleared");
    rd(12'h030, 0, "R9 cmd cleared");
    rd(12'h130, 0, "R9 lock cleared");

    repeat (2) @(posedge pclk);
    check(32'(q.size()), 0, "scoreboard drained");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule